// File: doc/BRIEF.md
# VPW Active Pulse Symbol Classifier

This block sits behind the receive synchronizer of a single-wire variable-pulse-width bus. It watches the filtered bus level and a 1 MHz timing tick, and it measures each active pulse in ticks. The count starts at the passive-to-active edge. When the pulse ends, the block sorts the length into ordered duration windows and reports a data 1, a data 0, a start-of-frame symbol or an invalid pulse. A pulse that stays active long enough to reach the break bound is reported as a break at once, while the bus is still active.

Each symbol appears as a one-cycle strobe with a 3-bit code. A separate sticky break flag tells the framing layer above to drop the frame in progress. It stays set until the next start-of-frame arrives. Passive symbols, byte framing, CRC and transmission are handled elsewhere.

Top module: `vpw_symbol_rx`

## Requirements
- R1: An active pulse of n ticks with 34 <= n < 96 is reported as data 1, code 3'b001.
- R2: An active pulse with 96 <= n < 163 is reported as data 0, code 3'b010.
- R3: An active pulse with 163 <= n <= 239 is reported as start-of-frame, code 3'b011.
- R4: An active pulse with n < 34, including a zero-tick glitch, is reported as invalid, code 3'b111, and never as a data symbol.
- R5: When the count reaches 240 ticks, a break, code 3'b100, is reported one cycle later without waiting for the pulse to end. Exactly one break is reported per pulse.
- R6: After a break, no further symbol is reported until the bus has gone passive. The end of the broken pulse produces no strobe.
- R7: breakFlag goes high with the break strobe. Data symbols and invalid pulses leave it unchanged. It is cleared in the same cycle that the next start-of-frame strobe appears.
- R8: The duration counter saturates at 240 and does not wrap. A bus held active for hundreds of ticks yields only the single break.
- R9: symValid lasts exactly one clock per symbol. symCode reads 3'b000 whenever symValid is low.
- R10: After reset, symValid, symCode and breakFlag are all zero.
- R11: Ticks that occur while the bus is passive, and the cycle of the rising edge itself, do not add to the next pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busActive | input | 1 | Synchronized, filtered bus level, 1 = active |
| tick | input | 1 | One-cycle strobe at 1 MHz |
| symValid | output | 1 | One-cycle strobe marking a reported symbol |
| symCode | output | 3 | Symbol code: 000 none, 001 one, 010 zero, 011 SOF, 100 break, 111 invalid |
| breakFlag | output | 1 | Set on break, cleared by the next start-of-frame |

## Verification
The bench drives pulses exactly on each side of every window bound: 33/34, 95/96, 162/163, 239/240 and 240/241. An off-by-one comparison therefore shows up as the neighbouring code. A pulse of 240 ticks that ends right after the limit has to produce one break and no trailing symbol. A 600-tick pulse would expose a counter that wraps, because the wrapped count would return as a second, short symbol after the break. The bench also interleaves data symbols between a break and the next start-of-frame. A design that cleared the flag on the wrong symbol would then show a flag mismatch. Ticks during passive gaps would corrupt the next measured length if they were counted.

// File: rtl/vpw_sym_pkg.sv
package vpw_sym_pkg;

  typedef enum logic [2:0] {
    SYM_NONE  = 3'b000,
    SYM_ONE   = 3'b001,
    SYM_ZERO  = 3'b010,
    SYM_SOF   = 3'b011,
    SYM_BREAK = 3'b100,
    SYM_BAD   = 3'b111
  } symCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic     rise;
    logic     fall;
    logic     atLimit;
    symCode_t endClass;
  } dpStat_t;

endpackage

// File: rtl/vpw_pulse_datapath.sv
module vpw_pulse_datapath
  import vpw_sym_pkg::*;
#(
  parameter int BND_A = 34,
  parameter int BND_B = 96,
  parameter int BND_C = 163,
  parameter int BND_D = 239,
  parameter int BND_E = 240,
  localparam int CNT_W = $clog2(BND_E + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busActive,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);

  localparam logic [CNT_W-1:0] LIM_A = CNT_W'(BND_A);
  localparam logic [CNT_W-1:0] LIM_B = CNT_W'(BND_B);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(BND_C);
  localparam logic [CNT_W-1:0] LIM_D = CNT_W'(BND_D);
  localparam logic [CNT_W-1:0] LIM_E = CNT_W'(BND_E);

  logic             prevActive;
  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) prevActive <= 1'b0;
    else       prevActive <= busActive;
  end

  // saturating increment: stuck-active bus never aliases back to short
  always_comb begin
    if (pulseCnt >= LIM_E) cntNext = LIM_E;
    else                   cntNext = pulseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pulseCnt <= '0;
    else if (ctrl.cntClear) pulseCnt <= '0;
    else if (ctrl.cntStep)  pulseCnt <= cntNext;
  end

  always_comb begin
    stat.rise    = busActive & ~prevActive;
    stat.fall    = ~busActive & prevActive;
    stat.atLimit = (pulseCnt >= LIM_E);
    if (pulseCnt < LIM_A)       stat.endClass = SYM_BAD;
    else if (pulseCnt < LIM_B)  stat.endClass = SYM_ONE;
    else if (pulseCnt < LIM_C)  stat.endClass = SYM_ZERO;
    else if (pulseCnt <= LIM_D) stat.endClass = SYM_SOF;
    else                        stat.endClass = SYM_BAD;
  end

  // counter holds at the limit when stepped again
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntStep && !ctrl.cntClear && pulseCnt == LIM_E) |=> pulseCnt == LIM_E);

  // a step never moves the count backwards
  assert_step_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntStep && !ctrl.cntClear) |=> pulseCnt >= $past(pulseCnt));

endmodule

// File: rtl/vpw_pulse_control.sv
module vpw_pulse_control
  import vpw_sym_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     busActive,
  input  logic     tick,
  input  dpStat_t  stat,
  output dpCtrl_t  ctrl,
  output logic     symValid,
  output symCode_t symCode,
  output logic     breakFlag
);

  logic lockOut;
  logic brkNow;
  logic endNow;

  always_comb begin
    ctrl.cntClear = stat.rise;
    ctrl.cntStep  = tick & busActive & ~stat.rise & ~lockOut;
    brkNow = stat.atLimit & ~lockOut & ~stat.rise & (busActive | stat.fall);
    endNow = stat.fall & ~lockOut & ~brkNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockOut   <= 1'b0;
      symValid  <= 1'b0;
      symCode   <= SYM_NONE;
      breakFlag <= 1'b0;
    end else begin
      if (brkNow)          lockOut <= 1'b1;
      else if (!busActive) lockOut <= 1'b0;

      symValid <= brkNow | endNow;
      if (brkNow)      symCode <= SYM_BREAK;
      else if (endNow) symCode <= stat.endClass;
      else             symCode <= SYM_NONE;

      if (brkNow)                                   breakFlag <= 1'b1;
      else if (endNow && stat.endClass == SYM_SOF)  breakFlag <= 1'b0;
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> !symValid);

  assert_code_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |-> symCode == SYM_NONE);

  assert_break_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && symCode == SYM_BREAK) |-> breakFlag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakFlag) |-> (symValid && symCode == SYM_SOF));

  assert_locked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && $past(lockOut)) |-> !symValid);

endmodule

// File: rtl/vpw_symbol_rx.sv
module vpw_symbol_rx
  import vpw_sym_pkg::*;
#(
  parameter int BND_A = 34,
  parameter int BND_B = 96,
  parameter int BND_C = 163,
  parameter int BND_D = 239,
  parameter int BND_E = 240
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busActive,
  input  logic       tick,
  output logic       symValid,
  output logic [2:0] symCode,
  output logic       breakFlag
);

  dpCtrl_t  ctrl;
  dpStat_t  stat;
  symCode_t codeInt;

  vpw_pulse_datapath #(
    .BND_A(BND_A), .BND_B(BND_B), .BND_C(BND_C), .BND_D(BND_D), .BND_E(BND_E)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .busActive(busActive),
    .ctrl     (ctrl),
    .stat     (stat)
  );

  vpw_pulse_control uControl (
    .clk      (clk),
    .rstN     (rstN),
    .busActive(busActive),
    .tick     (tick),
    .stat     (stat),
    .ctrl     (ctrl),
    .symValid (symValid),
    .symCode  (codeInt),
    .breakFlag(breakFlag)
  );

  assign symCode = codeInt;

endmodule

// File: tb/vpw_symbol_rx_test.sv
`timescale 1ns/100ps
module vpw_symbol_rx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busActive = 1'b0;
  logic       tick = 1'b0;
  logic       symValid;
  logic [2:0] symCode;
  logic       breakFlag;

  int  compared = 0;
  int  mismatched = 0;
  int  evCount = 0;
  int  lastCode = 0;
  bit  activeAt = 1'b0;
  int  idleBad = 0;
  bit  modelFlag = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  vpw_symbol_rx uut (
    .clk(clk), .rstN(rstN), .busActive(busActive), .tick(tick),
    .symValid(symValid), .symCode(symCode), .breakFlag(breakFlag)
  );

  // monitor, sampled shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (symValid) begin
        evCount++;
        lastCode = symCode;
        activeAt = busActive;
      end else if (symCode != 3'b000) begin
        idleBad++;
      end
    end
  end

  function automatic int expCode(int n);
    if (n < 34)        return 7;
    else if (n < 96)   return 1;
    else if (n < 163)  return 2;
    else if (n <= 239) return 3;
    else               return 4;
  endfunction

  function automatic string reqOf(int code);
    case (code)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drivePulse(int len, int gap);
    @(negedge clk); busActive = 1'b1; tick = 1'b0;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
    busActive = 1'b0;
    // ticks while passive (R11)
    for (int i = 0; i < gap; i++) begin
      tick = (i % 2 == 0); @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic runPulse(int len, string tag);
    int exp;
    exp = expCode(len);
    evCount = 0;
    drivePulse(len, 6 + int'($urandom % 20));
    if (exp == 4) modelFlag = 1'b1;
    else if (exp == 3) modelFlag = 1'b0;
    // exactly one strobe; for breaks this also covers R6/R8
    chk(evCount == 1, {tag, " count R6 ", reqOf(exp)}, evCount, 1);
    chk(lastCode == exp, {tag, " code ", reqOf(exp)}, lastCode, exp);
    if (len > 240)
      chk(activeAt == 1'b1, {tag, " R5 early break"}, int'(activeAt), 1);
    chk(breakFlag == modelFlag, {tag, " R7 flag"}, int'(breakFlag), int'(modelFlag));
  endtask

  initial begin
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(symValid == 1'b0, "R10 valid", int'(symValid), 0);
    chk(symCode == 3'b000, "R10 code", int'(symCode), 0);
    chk(breakFlag == 1'b0, "R10 flag", int'(breakFlag), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runPulse(50,  "R1");
    runPulse(240, "R5 exact");
    runPulse(60,  "R7 data keeps flag");
    runPulse(0,   "R4 glitch keeps flag");
    runPulse(170, "R3 clears flag");
    runPulse(0,   "R4");
    runPulse(33,  "R4 edge");
    runPulse(34,  "R1 edge");
    runPulse(95,  "R1 edge");
    runPulse(96,  "R2 edge");
    runPulse(162, "R2 edge");
    runPulse(163, "R3 edge");
    runPulse(239, "R3 edge");
    runPulse(241, "R5");
    runPulse(600, "R8 long");
    runPulse(200, "R3 after long");

    // R11: long passive stretch full of ticks, then a short pulse
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
    runPulse(40, "R11");

    for (int k = 0; k < 40; k++) begin
      int len;
      len = int'($urandom % 290);
      runPulse(len, "rand");
    end

    chk(idleBad == 0, "R9 idle code", idleBad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule